// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog peripheral on a simple synchronous register bus. It protects its configuration with a key handshake. Writes to the counter register are not loaded into the count. The block reads their low 16 bits as key words. One pair of consecutive key words opens the configuration registers for a short time. A different pair restarts the count.

Once enabled, the count advances on ticks from one of four selectable sources. When the count reaches the programmed limit, the block holds the count, sets a sticky expiry flag and pulses a reset request for one cycle. A nonzero window value makes a restart that comes too early a fault, with the same outcome. A control bit decides whether the configuration can ever be opened again.

Top module: `keyed_wdt`

Register byte offsets:

| Offset | Register | Contents |
|---|---|---|
| 0 | control A | bit 7 counter enable; bit 5 later updates allowed; other bits read 0 |
| 1 | control B | bit 6 expiry flag; bits 1:0 tick source select; other bits read 0 |
| 4 | count | read returns the count; writes are key words |
| 8 | limit | 32-bit timeout limit |
| 12 | window | 32-bit refresh window |

Any other offset reads 0.

## Requirements
- R1: After reset, the registers read as follows: control A = 0x20, control B = 0x00, count = 0, limit = `DEF_LIMIT`, window = 0. `rst_req` is low.
- R2: Writing 0xC520 and then 0xD928 to offset 4, as two consecutive bus writes, opens the configuration. While it is closed, writes to offsets 0, 8 and 12 and to the select bits of offset 1 have no effect.
- R3: A key pair that is broken has no effect. This covers a wrong second word and any bus write placed between the two words.
- R4: An open configuration closes after `UNLOCK_CYCLES` bus cycles, and also at any write to control A.
- R5: If control A is written with bit 5 clear, every later unlock pair is ignored until reset.
- R6: With control A bit 7 set, the count rises by one on each tick of the selected source. With bit 7 clear, the count holds.
- R7: Control B bits 1:0 select the tick source: 0 = every bus cycle, 1 = `tick_lp`, 2 = `tick_mid`, 3 = `tick_ext`. The other tick inputs are ignored.
- R8: When the enabled count equals the limit, the count holds. One cycle later, `rst_req` is high for exactly one cycle and the flag (control B bit 6) is set.
- R9: Writing 0xA602 and then 0xB480 to offset 4, as consecutive writes, restarts the count at 0 on that write's clock edge.
- R10: Writing 1 to control B bit 6 clears the flag even when the configuration is closed. Writing 0 to that bit leaves the flag set.
- R11: With window = 0, a restart is accepted at any count. With a nonzero window, a restart pair completed while count < window does not restart the count. Instead it pulses `rst_req` on the next cycle and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| tick_lp | input | 1 | Low-power tick enable (source 1) |
| tick_mid | input | 1 | 32 kHz tick enable (source 2) |
| tick_ext | input | 1 | External tick enable (source 3) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach from the ports is a window violation. It needs a restart pair that completes while the count is still below a nonzero window. That state only exists right after a restart that was itself accepted.

The stimulus builds it in steps. It opens the configuration, sets the window and a large limit, and then waits until the count is past the window. It then issues one restart that is accepted and a second one right after it, whose final word lands at count 1. A second hard case is the edge of the unlock timeout, which the stimulus reaches by timing writes just inside and well past the open period.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [15:0] KEY_OPEN_A = 16'hC520;
  localparam logic [15:0] KEY_OPEN_B = 16'hD928;
  localparam logic [15:0] KEY_FEED_A = 16'hA602;
  localparam logic [15:0] KEY_FEED_B = 16'hB480;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_OPEN = 2'd1,
    KS_FEED = 2'd2
  } key_state_t;

  // tick enable chosen by the 2-bit source field
  function automatic logic pick_tick(input logic [1:0] sel, input logic lp,
                                     input logic mid, input logic ext);
    case (sel)
      2'd0:    pick_tick = 1'b1;
      2'd1:    pick_tick = lp;
      2'd2:    pick_tick = mid;
      default: pick_tick = ext;
    endcase
  endfunction

  // an early restart is a fault only when a window is programmed
  function automatic logic too_early(input logic [31:0] cnt, input logic [31:0] win);
    too_early = (win != 32'd0) && (cnt < win);
  endfunction
endpackage

// File: rtl/kwdt_keydec.sv
module kwdt_keydec
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        any_wr,
  input  logic        key_wr,
  input  logic [15:0] key,
  output logic        open_evt,
  output logic        feed_evt
);
  key_state_t st_q, st_d;

  always_comb begin
    st_d     = st_q;
    open_evt = 1'b0;
    feed_evt = 1'b0;
    if (any_wr) begin
      if (!key_wr) begin
        st_d = KS_IDLE;
      end else begin
        open_evt = (st_q == KS_OPEN) && (key == KEY_OPEN_B);
        feed_evt = (st_q == KS_FEED) && (key == KEY_FEED_B);
        if (open_evt || feed_evt)    st_d = KS_IDLE;
        else if (key == KEY_OPEN_A)  st_d = KS_OPEN;
        else if (key == KEY_FEED_A)  st_d = KS_FEED;
        else                         st_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;

  assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_evt && feed_evt));
  assert_pair_needs_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !key_wr) |=> !open_evt && !feed_evt);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] window,
  input  logic             feed,
  output logic [CNT_W-1:0] count,
  output logic             trip,
  output logic             rst_req
);
  logic [CNT_W-1:0] count_q;
  logic             fired_q, rst_q;
  logic             expire, viol, restart;

  assign viol    = feed && too_early(count_q, window);
  assign restart = feed && !viol;
  assign expire  = en && (count_q == limit) && !fired_q;
  assign trip    = expire || viol;
  assign count   = count_q;
  assign rst_req = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      fired_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= trip;
      if (restart) begin
        count_q <= '0;
        fired_q <= 1'b0;
      end else begin
        if (expire) fired_q <= 1'b1;
        if (en && tick && count_q != limit) count_q <= count_q + 1'b1;
      end
    end
  end

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && count_q != limit && !feed) |=> count_q == $past(count_q) + 1'b1);
  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !feed) |=> $stable(count_q));
  assert_hold_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == limit && !feed) |=> $stable(count_q));
  assert_early_feed_resets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> rst_req && count_q != '0);
  assert_feed_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count_q == '0);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int          DATA_W        = 32,
  parameter int          ADDR_W        = 4,
  parameter int          UNLOCK_CYCLES = 256,
  parameter logic [31:0] DEF_LIMIT     = 32'd1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_lp,
  input  logic              tick_mid,
  input  logic              tick_ext,
  output logic              rst_req
);
  localparam int UT_W = (UNLOCK_CYCLES > 2) ? $clog2(UNLOCK_CYCLES) : 1;
  localparam logic [UT_W-1:0] UT_LOAD = UT_W'(UNLOCK_CYCLES - 1);

  logic              en_q, upd_q, flag_q, unlocked_q;
  logic [1:0]        sel_q;
  logic [DATA_W-1:0] limit_q, window_q, count;
  logic [UT_W-1:0]   ut_q;
  logic              wr, wr_a, wr_b, wr_lim, wr_win, wr_key;
  logic              open_evt, feed_evt, open_ok, trip, tick;

  assign wr     = bus_sel && bus_wr;
  assign wr_a   = wr && bus_addr == ADDR_W'(0);
  assign wr_b   = wr && bus_addr == ADDR_W'(1);
  assign wr_key = wr && bus_addr == ADDR_W'(4);
  assign wr_lim = wr && bus_addr == ADDR_W'(8);
  assign wr_win = wr && bus_addr == ADDR_W'(12);
  assign open_ok = open_evt && upd_q;
  assign tick    = pick_tick(sel_q, tick_lp, tick_mid, tick_ext);

  kwdt_keydec u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_wr   (wr),
    .key_wr   (wr_key),
    .key      (bus_wdata[15:0]),
    .open_evt (open_evt),
    .feed_evt (feed_evt)
  );

  kwdt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .tick    (tick),
    .limit   (limit_q),
    .window  (window_q),
    .feed    (feed_evt),
    .count   (count),
    .trip    (trip),
    .rst_req (rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      ut_q       <= '0;
      en_q       <= 1'b0;
      upd_q      <= 1'b1;
      sel_q      <= 2'd0;
      limit_q    <= DATA_W'(DEF_LIMIT);
      window_q   <= '0;
    end else begin
      if (unlocked_q) begin
        if (wr_lim) limit_q  <= bus_wdata;
        if (wr_win) window_q <= bus_wdata;
        if (wr_b)   sel_q    <= bus_wdata[1:0];
        if (wr_a) begin
          en_q  <= bus_wdata[7];
          upd_q <= bus_wdata[5];
        end
      end
      if (open_ok) begin
        unlocked_q <= 1'b1;
        ut_q       <= UT_LOAD;
      end else if (unlocked_q && (wr_a || ut_q == '0)) begin
        unlocked_q <= 1'b0;
      end else if (unlocked_q) begin
        ut_q <= ut_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     flag_q <= 1'b0;
    else if (trip)                  flag_q <= 1'b1;
    else if (wr_b && bus_wdata[6])  flag_q <= 1'b0;

  always_comb begin
    case (bus_addr)
      ADDR_W'(0):  bus_rdata = DATA_W'({en_q, 1'b0, upd_q, 5'b0});
      ADDR_W'(1):  bus_rdata = DATA_W'({1'b0, flag_q, 4'b0, sel_q});
      ADDR_W'(4):  bus_rdata = count;
      ADDR_W'(8):  bus_rdata = limit_q;
      ADDR_W'(12): bus_rdata = window_q;
      default:     bus_rdata = '0;
    endcase
  end

  assert_locked_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |=> $stable(limit_q) && $stable(window_q));
  assert_close_on_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked_q && wr_a) |=> !unlocked_q);
  assert_sticky_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |=> !unlocked_q);
  assert_flag_on_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> flag_q);
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && bus_wdata[6] && !trip) |=> !flag_q);
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_lp = 1'b0, tick_mid = 1'b0, tick_ext = 1'b0;
  logic        rst_req;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  keyed_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_lp(tick_lp), .tick_mid(tick_mid), .tick_ext(tick_ext), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic unlock; wr(4, 32'hC520); wr(4, 32'hD928); endtask
  task automatic feed;   wr(4, 32'hA602); wr(4, 32'hB480); endtask

  task automatic t_reset;
    logic [31:0] v;
    cyc(10);
    rd(0, v);  check("R1 ctrlA", v, 32'h20);
    rd(1, v);  check("R1 ctrlB", v, 32'h0);
    rd(4, v);  check("R1/R6 count held while disabled", v, 32'h0);
    rd(8, v);  check("R1 limit", v, 32'd1000);
    rd(12, v); check("R1 window", v, 32'h0);
    check("R1 rst_req", rst_req, 1'b0);
  endtask

  task automatic t_locked;
    logic [31:0] v;
    wr(8, 32'd50); rd(8, v); check("R2 locked write ignored", v, 32'd1000);
    wr(4, 32'hC520); wr(12, 32'd5); wr(4, 32'hD928);
    wr(8, 32'd50); rd(8, v); check("R3 interrupted pair", v, 32'd1000);
    wr(4, 32'hC520); wr(4, 32'h1234); wr(4, 32'hD928);
    wr(8, 32'd50); rd(8, v); check("R3 wrong second word", v, 32'd1000);
  endtask

  task automatic t_timeout;
    logic [31:0] v;
    unlock(); wr(8, 32'd20); rd(8, v); check("R2 unlocked write", v, 32'd20);
    wr(1, 32'h0); wr(0, 32'hA0);
    for (int i = 1; i <= 22; i++) begin
      cyc(1);
      rd(4, v);
      if (i == 19) check("R6 count step", v, 32'd19);
      if (i == 20) check("R8 no request yet", rst_req, 1'b0);
      if (i == 21) check("R8 request pulse", rst_req, 1'b1);
      if (i == 22) begin
        check("R8 request one cycle", rst_req, 1'b0);
        check("R8 count held", v, 32'd20);
      end
    end
    rd(1, v); check("R8 flag set", v, 32'h40);
    wr(8, 32'd99); rd(8, v); check("R4 closed by ctrlA write", v, 32'd20);
  endtask

  task automatic t_flag;
    logic [31:0] v;
    wr(1, 32'h03); rd(1, v); check("R10 write 0 keeps flag, R2 sel locked", v, 32'h40);
    wr(1, 32'h40); rd(1, v); check("R10 W1C while locked", v, 32'h0);
  endtask

  task automatic t_feed;
    logic [31:0] v;
    feed(); rd(4, v); check("R9 restart to 0", v, 32'd0);
    check("R11 window 0 accepts", rst_req, 1'b0);
    cyc(5); rd(4, v); check("R9 counting after restart", v, 32'd5);
    wr(4, 32'hA602); wr(12, 32'h0); wr(4, 32'hB480);
    rd(4, v); check("R9/R3 broken restart pair", v, 32'd8);
  endtask

  task automatic t_window;
    logic [31:0] v;
    unlock(); wr(12, 32'd10); wr(8, 32'd200); wr(0, 32'hA0);
    feed(); rd(4, v); check("R11 late restart accepted", v, 32'd0);
    feed(); rd(4, v);
    check("R11 early restart request", rst_req, 1'b1);
    check("R11 early restart no restart", v, 32'd2);
    cyc(1); check("R11 request one cycle", rst_req, 1'b0);
    rd(1, v); check("R11 flag set", v, 32'h40);
    cyc(10); feed(); rd(4, v); check("R11 restart past window", v, 32'd0);
    wr(1, 32'h40);
  endtask

  task automatic pulse(input int which);
    if (which == 1) tick_lp = 1'b1; else if (which == 2) tick_mid = 1'b1; else tick_ext = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_lp = 1'b0; tick_mid = 1'b0; tick_ext = 1'b0;
  endtask

  task automatic t_source;
    logic [31:0] v;
    unlock(); wr(12, 32'd0); wr(1, 32'h01); wr(0, 32'hA0);
    feed(); cyc(10); rd(4, v); check("R7 no tick no count", v, 32'd0);
    pulse(1); pulse(1); pulse(1); rd(4, v); check("R7 lp ticks counted", v, 32'd3);
    pulse(3); pulse(2); rd(4, v); check("R7 other ticks ignored", v, 32'd3);
  endtask

  task automatic t_unlock_timer;
    logic [31:0] v;
    unlock(); cyc(250); wr(8, 32'd201); rd(8, v); check("R4 still open", v, 32'd201);
    cyc(20); wr(8, 32'd202); rd(8, v); check("R4 timed out", v, 32'd201);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    unlock(); wr(0, 32'h80);
    unlock(); wr(8, 32'd7); rd(8, v); check("R5 permanent lock", v, 32'd201);
    rd(0, v); check("R5 ctrlA", v, 32'h80);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_locked(); t_timeout(); t_flag(); t_feed();
    t_window(); t_source(); t_unlock_timer(); t_lock();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule